// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns three configuration bytes into the bit clocking that a CAN controller needs. A prescaler divides the oscillator clock into time quanta. A segment sequencer then counts those quanta through one bit: a single synchronisation quantum, the propagation segment, phase segment one and phase segment two. It reports where each bit starts, where the receive line is sampled, and where the bit ends.

A falling edge on the already-synchronised receive line, which is a recessive-to-dominant transition, resynchronises the bit. An edge that comes before the sample point stretches phase segment one. An edge that comes after it trims phase segment two. The change is never larger than the synchronisation jump width, and only one edge per bit counts. The block also samples the line at the sample point, either once or as a majority of three quantum samples, and raises a flag when the configuration is not legal. It carries no frame data, so it has no valid/ready interface and no back-pressure. Every output is a plain control pulse or level. The strobes last one clock and have no handshake.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2 × (P + 1) clock cycles, where P is cfg_rate[5:0]. After enable rises, the first tq_tick comes in the clock 2 × (P + 1) − 1 cycles later, and tq_tick is never high in two cycles in a row.
- R2: A bit with no resynchronisation lasts 1 + prop + ps1 + ps2 quanta. sync_mark is high for the whole first quantum of every bit. bit_end pulses together with the tq_tick that closes the last quantum of phase segment two.
- R3: sample_strobe pulses together with the tq_tick that closes the last quantum of phase segment one. It never coincides with bit_end.
- R4: Each length is stored as length − 1. The fields are: jump width in cfg_rate[7:6]; ps1 in cfg_seg[5:3]; prop in cfg_seg[2:0]; ps2 in cfg_ps2[2:0], used only when cfg_seg[7] = 1. When cfg_seg[7] = 0, ps2 is the larger of ps1 and 2, and cfg_ps2 has no effect.
- R5: cfg_err is high exactly when not (prop + ps1 ≥ ps2 and ps2 > jump width). While it is high, no tq_tick and no strobe is produced.
- R6: While enable is low, tq_tick, sync_mark, sample_strobe and bit_end stay low. Raising enable restarts timing at the start of a synchronisation quantum.
- R7: A falling edge of rx_in in quantum q of the bit, with 1 ≤ q ≤ prop + ps1 and quantum 0 being the sync quantum, lengthens phase segment one by min(q, jump width) quanta.
- R8: A falling edge in quantum q of phase segment two shortens that segment by min(N − q − 1, jump width) quanta, where N is the nominal bit length. The quantum holding the edge is therefore always kept.
- R9: Only the first qualifying edge in a bit is applied. An edge in the sync quantum has no effect and does not use up the bit's one resynchronisation.
- R10: An edge in the same clock as the tq_tick that would close phase segment one or phase segment two takes effect in that clock.
- R11: rx_bit updates in the clock after sample_strobe. With cfg_seg[6] = 0 it takes rx_in from the strobe clock. With cfg_seg[6] = 1 it takes the majority of rx_in at the last three quantum ticks, the strobe tick included.
- R12: After reset, all strobes are low and rx_bit is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the timing when high |
| cfg_rate | input | 8 | Jump width − 1 [7:6], prescaler value [5:0] |
| cfg_seg | input | 8 | ps2 source select [7], triple sampling [6], ps1 − 1 [5:3], prop − 1 [2:0] |
| cfg_ps2 | input | 3 | ps2 − 1 |
| rx_in | input | 1 | Synchronised receive line, 1 = recessive |
| tq_tick | output | 1 | One-clock pulse at the end of each quantum |
| sync_mark | output | 1 | High during the sync quantum |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| bit_end | output | 1 | One-clock pulse at the end of the bit |
| rx_bit | output | 1 | Bit value taken at the sample point |
| cfg_err | output | 1 | Configuration is illegal |

## Verification
A resynchronising edge can arrive in the very clock where a quantum tick closes phase segment one or phase segment two. The sequencer must then decide the segment boundary using the new adjustment rather than the old length. Directed cases place the falling edge exactly on the tick clock of the would-be sample point, and on the tick clock of the second-to-last phase-two quantum. The bench then compares every clock's strobes with a quantum-index model, which has to show the moved sample point and a bit that ends in the edge clock itself.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PS1  = 2'd2,
    SEG_PS2  = 2'd3
  } seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_cfg_decode.sv
module can_bt_cfg_decode #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2,
  parameter int LEN_W = SEG_W + 3
) (
  input  logic [SJW_W+BRP_W-1:0] cfg_rate,
  input  logic [2*SEG_W+1:0]     cfg_seg,
  input  logic [SEG_W-1:0]       cfg_ps2,
  output logic [BRP_W-1:0]       brp,
  output logic [LEN_W-1:0]       sjw_len,
  output logic [LEN_W-1:0]       prop_len,
  output logic [LEN_W-1:0]       ps1_len,
  output logic [LEN_W-1:0]       ps2_len,
  output logic                   triple,
  output logic                   cfg_err
);
  localparam int TRIPLE_BIT = 2 * SEG_W;
  localparam int SEL_BIT    = 2 * SEG_W + 1;
  localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);
  localparam logic [LEN_W-1:0] PS2_MIN = LEN_W'(2);

  logic [LEN_W-1:0] ps2_auto;

  assign brp      = cfg_rate[BRP_W-1:0];
  assign sjw_len  = LEN_W'(cfg_rate[SJW_W+BRP_W-1:BRP_W]) + ONE;
  assign prop_len = LEN_W'(cfg_seg[SEG_W-1:0]) + ONE;
  assign ps1_len  = LEN_W'(cfg_seg[2*SEG_W-1:SEG_W]) + ONE;
  assign triple   = cfg_seg[TRIPLE_BIT];

  // automatic phase-two length: never shorter than the information processing time
  assign ps2_auto = (ps1_len > PS2_MIN) ? ps1_len : PS2_MIN;
  assign ps2_len  = cfg_seg[SEL_BIT] ? (LEN_W'(cfg_ps2) + ONE) : ps2_auto;

  always_comb begin
    cfg_err = 1'b0;
    if ((prop_len + ps1_len) < ps2_len) cfg_err = 1'b1;
    if (ps2_len <= sjw_len)             cfg_err = 1'b1;
  end

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_tick
);
  localparam int CNT_W = BRP_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;

  // terminal count 2*brp+1 gives a period of 2*(brp+1) clocks
  assign term    = {brp, 1'b1};
  assign tq_tick = run && (cnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || tq_tick)  cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/can_bt_segmenter.sv
module can_bt_segmenter
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tq_tick,
  input  logic             edge_fall,
  input  logic [LEN_W-1:0] sjw_len,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ps1_len,
  input  logic [LEN_W-1:0] ps2_len,
  output logic             sync_mark,
  output logic             sample_strobe,
  output logic             bit_end
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seg_e             seg;
  logic [LEN_W-1:0] qcnt;
  logic [LEN_W-1:0] ext_q;
  logic [LEN_W-1:0] cut_q;
  logic             done_q;

  logic             take;
  logic             in_front;
  logic [LEN_W-1:0] e_pos;
  logic [LEN_W-1:0] rem_m1;
  logic [LEN_W-1:0] ext_new;
  logic [LEN_W-1:0] cut_new;
  logic [LEN_W-1:0] ps1_end;
  logic [LEN_W-1:0] ps2_end;
  logic [LEN_W-1:0] seg_len;
  logic             last_q;

  // the live adjustment joins the boundary compare in the edge clock itself
  always_comb begin
    in_front = (seg == SEG_PROP) || (seg == SEG_PS1);
    take     = run && edge_fall && !done_q && (seg != SEG_SYNC);
    e_pos    = (seg == SEG_PROP) ? (qcnt + ONE) : (prop_len + qcnt + ONE);
    rem_m1   = ps2_len - qcnt - ONE;
    ext_new  = '0;
    cut_new  = '0;
    if (take && in_front)         ext_new = (e_pos  < sjw_len) ? e_pos  : sjw_len;
    if (take && seg == SEG_PS2)   cut_new = (rem_m1 < sjw_len) ? rem_m1 : sjw_len;
    ps1_end  = ps1_len + ext_q + ext_new;
    ps2_end  = ps2_len - cut_q - cut_new;
    case (seg)
      SEG_SYNC: seg_len = ONE;
      SEG_PROP: seg_len = prop_len;
      SEG_PS1:  seg_len = ps1_end;
      default:  seg_len = ps2_end;
    endcase
    last_q = (qcnt == (seg_len - ONE));
  end

  assign sync_mark     = run && (seg == SEG_SYNC);
  assign sample_strobe = tq_tick && (seg == SEG_PS1) && last_q;
  assign bit_end       = tq_tick && (seg == SEG_PS2) && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg    <= SEG_SYNC;
      qcnt   <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      done_q <= 1'b0;
    end else if (!run) begin
      seg    <= SEG_SYNC;
      qcnt   <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (take) begin
        done_q <= 1'b1;
        if (in_front) ext_q <= ext_new;
        else          cut_q <= cut_new;
      end
      if (tq_tick) begin
        if (last_q) begin
          qcnt <= '0;
          seg  <= seg_e'(seg + 2'd1);
          if (seg == SEG_PS2) begin
            ext_q  <= '0;
            cut_q  <= '0;
            done_q <= 1'b0;
          end
        end else begin
          qcnt <= qcnt + ONE;
        end
      end
    end
  end

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tq_tick,
  input  logic sample_strobe,
  input  logic triple,
  input  logic rx_in,
  output logic rx_bit
);
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= 2'b11;
      rx_bit <= 1'b1;
    end else begin
      if (!run)         hist <= 2'b11;
      else if (tq_tick) hist <= {hist[0], rx_in};
      if (sample_strobe)
        rx_bit <= triple ? maj3(hist[1], hist[0], rx_in) : rx_in;
    end
  end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [SJW_W+BRP_W-1:0] cfg_rate,
  input  logic [2*SEG_W+1:0]     cfg_seg,
  input  logic [SEG_W-1:0]       cfg_ps2,
  input  logic                   rx_in,
  output logic                   tq_tick,
  output logic                   sync_mark,
  output logic                   sample_strobe,
  output logic                   bit_end,
  output logic                   rx_bit,
  output logic                   cfg_err
);
  localparam int LEN_W = SEG_W + 3;

  logic [BRP_W-1:0] brp;
  logic [LEN_W-1:0] sjw_len, prop_len, ps1_len, ps2_len;
  logic             triple;
  logic             run;
  logic             rx_prev;
  logic             edge_fall;

  can_bt_cfg_decode #(.BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W), .LEN_W(LEN_W)) u_dec (
    .cfg_rate(cfg_rate), .cfg_seg(cfg_seg), .cfg_ps2(cfg_ps2),
    .brp(brp), .sjw_len(sjw_len), .prop_len(prop_len), .ps1_len(ps1_len),
    .ps2_len(ps2_len), .triple(triple), .cfg_err(cfg_err)
  );

  assign run = enable && !cfg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= rx_in;
  end

  assign edge_fall = rx_prev && !rx_in;

  can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .brp(brp), .tq_tick(tq_tick)
  );

  can_bt_segmenter #(.LEN_W(LEN_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .run(run), .tq_tick(tq_tick), .edge_fall(edge_fall),
    .sjw_len(sjw_len), .prop_len(prop_len), .ps1_len(ps1_len), .ps2_len(ps2_len),
    .sync_mark(sync_mark), .sample_strobe(sample_strobe), .bit_end(bit_end)
  );

  can_bt_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .run(run), .tq_tick(tq_tick),
    .sample_strobe(sample_strobe), .triple(triple), .rx_in(rx_in), .rx_bit(rx_bit)
  );

endmodule

// File: rtl/can_bit_timer_sva.sv
module can_bit_timer_sva (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tq_tick,
  input logic sync_mark,
  input logic sample_strobe,
  input logic bit_end,
  input logic rx_bit,
  input logic cfg_err
);

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);

  p_end_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> tq_tick);

  p_sync_follows_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (sync_mark || !enable || cfg_err));

  p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> tq_tick);

  p_strobes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_strobe && bit_end));

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(tq_tick || sample_strobe || bit_end));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(tq_tick || sync_mark || sample_strobe || bit_end));

  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_strobe) |-> $stable(rx_bit));

endmodule

bind can_bit_timer can_bit_timer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tq_tick(tq_tick),
  .sync_mark(sync_mark), .sample_strobe(sample_strobe), .bit_end(bit_end),
  .rx_bit(rx_bit), .cfg_err(cfg_err)
);

// File: tb/can_bit_timer_test.sv
`timescale 1ns/1ps
module can_bit_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] cfg_rate = 8'h41;
  logic [7:0] cfg_seg = 8'h91;
  logic [2:0] cfg_ps2 = 3'd2;
  logic       rx_in = 1'b1;
  logic       tq_tick, sync_mark, sample_strobe, bit_end, rx_bit, cfg_err;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int g_L, g_prop, g_ps1, g_ps2, g_sjw, g_N, g_p1_0, g_p2_0;

  always #2 clk = ~clk;

  can_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_rate(cfg_rate),
    .cfg_seg(cfg_seg), .cfg_ps2(cfg_ps2), .rx_in(rx_in), .tq_tick(tq_tick),
    .sync_mark(sync_mark), .sample_strobe(sample_strobe), .bit_end(bit_end),
    .rx_bit(rx_bit), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic decode(input logic [7:0] a, input logic [7:0] b, input logic [2:0] c,
                        output int brp, output int sjw, output int prop,
                        output int ps1, output int ps2, output bit legal);
    brp   = a[5:0];
    sjw   = a[7:6] + 1;
    prop  = b[2:0] + 1;
    ps1   = b[5:3] + 1;
    ps2   = b[7] ? (c + 1) : ((ps1 > 2) ? ps1 : 2);
    legal = (prop + ps1 >= ps2) && (ps2 > sjw);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic rx_for(input int j, input int e1, input int e2);
    logic r = 1'b1;
    if (e1 >= 0 && j >= e1) r = 1'b0;
    if (e2 >= 0 && j > e1 && j < e2) r = 1'b1;
    return r;
  endfunction

  // expected {tick, sync, sample, end} at sample index j after enable
  function automatic logic [3:0] exp_flags(input int j);
    int  qi, q, p1, nb, n0;
    bit  tk;
    qi = j / g_L;
    tk = (j % g_L) == (g_L - 1);
    n0 = 1 + g_prop + g_p1_0 + g_p2_0;
    if (qi < n0) begin q = qi; p1 = g_p1_0; nb = n0; end
    else begin q = (qi - n0) % g_N; p1 = g_ps1; nb = g_N; end
    return {tk, q == 0, tk && (q == g_prop + p1), tk && (q == nb - 1)};
  endfunction

  // bench model of resynchronisation in the first bit (R7, R8, R9)
  task automatic apply_edges(input int e1, input int e2);
    bit done = 0;
    int es[2];
    g_p1_0 = g_ps1;
    g_p2_0 = g_ps2;
    es[0] = e1; es[1] = e2;
    for (int k = 0; k < 2; k++) begin
      int qe;
      if (es[k] < 0 || done) continue;
      qe = es[k] / g_L;
      if (qe == 0 || qe >= g_N) continue;
      if (qe <= g_prop + g_ps1) g_p1_0 = g_ps1 + imin(qe, g_sjw);
      else                      g_p2_0 = g_ps2 - imin(g_N - qe - 1, g_sjw);
      done = 1;
    end
  endtask

  task automatic run_timing(input logic [7:0] a, input logic [7:0] b, input logic [2:0] c,
                            input int nbits, input int e1, input int e2, input string req);
    int brp, sjw, prop, ps1, ps2, nsamp;
    bit legal;
    @(negedge clk);
    enable = 1'b0; rx_in = 1'b1; cfg_rate = a; cfg_seg = b; cfg_ps2 = c;
    repeat (2) @(negedge clk);
    #1;
    check({tq_tick, sync_mark, sample_strobe, bit_end} == 4'b0, "R6", "idle strobes",
          {tq_tick, sync_mark, sample_strobe, bit_end}, 0);
    decode(a, b, c, brp, sjw, prop, ps1, ps2, legal);
    g_L = 2 * (brp + 1); g_prop = prop; g_ps1 = ps1; g_ps2 = ps2; g_sjw = sjw;
    g_N = 1 + prop + ps1 + ps2;
    apply_edges(e1, e2);
    nsamp = nbits * g_N * g_L;
    for (int j = 0; j < nsamp; j++) begin
      logic [3:0] got, ex;
      @(negedge clk);
      enable = 1'b1;
      rx_in = rx_for(j, e1, e2);
      #1;
      got = {tq_tick, sync_mark, sample_strobe, bit_end};
      ex  = exp_flags(j);
      check(got == ex, req, $sformatf("strobes {tick,sync,sample,end} at clock %0d", j), got, ex);
    end
    @(negedge clk);
    enable = 1'b0;
    rx_in = 1'b1;
  endtask

  task automatic run_sampler(input logic [7:0] a, input logic [7:0] b, input logic [2:0] c,
                             input int nsamp);
    int brp, sjw, prop, ps1, ps2;
    bit legal, pend;
    logic h0, h1, pexp;
    @(negedge clk);
    enable = 1'b0; rx_in = 1'b1; cfg_rate = a; cfg_seg = b; cfg_ps2 = c;
    repeat (2) @(negedge clk);
    decode(a, b, c, brp, sjw, prop, ps1, ps2, legal);
    g_L = 2 * (brp + 1);
    h0 = 1'b1; h1 = 1'b1; pend = 0; pexp = 1'b1;
    for (int j = 0; j < nsamp; j++) begin
      @(negedge clk);
      enable = 1'b1;
      if (j % g_L == 0) rx_in = 1'($urandom_range(0, 1));
      #1;
      if (pend) begin
        check(rx_bit == pexp, "R11", b[6] ? "majority sample" : "single sample",
              rx_bit, pexp);
        pend = 0;
      end
      if (sample_strobe) begin
        pexp = b[6] ? ((h1 & h0) | (h1 & rx_in) | (h0 & rx_in)) : rx_in;
        pend = 1;
      end
      if (tq_tick) begin h1 = h0; h0 = rx_in; end
    end
    @(negedge clk);
    enable = 1'b0;
    rx_in = 1'b1;
  endtask

  task automatic run_illegal(input logic [7:0] a, input logic [7:0] b, input logic [2:0] c);
    int brp, sjw, prop, ps1, ps2, ticks;
    bit legal;
    @(negedge clk);
    enable = 1'b0; cfg_rate = a; cfg_seg = b; cfg_ps2 = c;
    decode(a, b, c, brp, sjw, prop, ps1, ps2, legal);
    #1;
    check(cfg_err == !legal, "R5", "cfg_err flag", cfg_err, !legal);
    if (!legal) begin
      ticks = 0;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        enable = 1'b1;
        #1;
        if (tq_tick || sample_strobe || bit_end) ticks++;
      end
      check(ticks == 0, "R5", "timing pulses while illegal", ticks, 0);
      @(negedge clk);
      enable = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R12: reset state
    check({tq_tick, sync_mark, sample_strobe, bit_end} == 4'b0, "R12", "strobes in reset",
          {tq_tick, sync_mark, sample_strobe, bit_end}, 0);
    check(rx_bit == 1'b1, "R12", "rx_bit in reset", rx_bit, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(rx_bit == 1'b1 && !tq_tick, "R12", "after reset release", {rx_bit, tq_tick}, 2);

    // R2 R3: nominal bits, quanta 1+2+3+3, quantum of 4 clocks
    run_timing(8'h41, 8'h91, 3'd2, 4, -1, -1, "R2 R3 nominal");
    // R1 R4: largest prescaler, automatic ps2 floors at 2, cfg_ps2 ignored
    run_timing(8'h3F, 8'h03, 3'd7, 2, -1, -1, "R1 R4 slow quantum");
    // R4: automatic ps2 follows ps1 = 6; cfg_ps2 = 0 would be illegal if used
    run_timing(8'h00, 8'h28, 3'd0, 3, -1, -1, "R4 auto ps2");
    // R7: edge in propagation segment, then in phase one
    run_timing(8'h41, 8'h91, 3'd2, 3, 5, -1, "R7 edge in prop");
    run_timing(8'h41, 8'h91, 3'd2, 3, 17, -1, "R7 edge in ps1");
    // R8: edge early in phase two
    run_timing(8'h41, 8'h91, 3'd2, 3, 25, -1, "R8 edge in ps2");
    // R10: edge on the tick that would end ps2 early, and on the sample-point tick
    run_timing(8'h41, 8'h91, 3'd2, 3, 31, -1, "R10 R8 edge on ps2 tick");
    run_timing(8'h41, 8'h91, 3'd2, 3, 23, -1, "R10 R7 edge on sample tick");
    // R9: edge in sync ignored, later edge applied; second edge in a bit ignored
    run_timing(8'h41, 8'h91, 3'd2, 3, 1, 17, "R9 sync edge");
    run_timing(8'h41, 8'h91, 3'd2, 3, 9, 29, "R9 second edge");

    // R5: directed illegal settings
    run_illegal(8'hC0, 8'h9B, 3'd3);
    run_illegal(8'h00, 8'h80, 3'd2);

    // random legal timings and random legality
    for (int k = 0; k < 12; k++) begin
      logic [7:0] a, b;
      logic [2:0] c;
      int brp, sjw, prop, ps1, ps2;
      bit legal;
      do begin
        a = {2'($urandom_range(0, 3)), 6'($urandom_range(0, 5))};
        b = {1'($urandom_range(0, 1)), 1'b0, 3'($urandom), 3'($urandom)};
        c = 3'($urandom);
        decode(a, b, c, brp, sjw, prop, ps1, ps2, legal);
      end while (!legal);
      run_timing(a, b, c, 3, -1, -1, "R2 R3 R4 random");
    end
    for (int k = 0; k < 20; k++)
      run_illegal(8'($urandom), 8'($urandom), 3'($urandom));

    // R11: single and majority sampling under random line activity
    run_sampler(8'h41, 8'h91, 3'd2, 600);
    run_sampler(8'h41, 8'hD1, 3'd2, 600);
    run_sampler(8'h00, 8'hD1, 3'd2, 400);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule